// File: doc/BRIEF.md
# Outbound Address Window Translator

This block turns CPU-side local bus addresses into PCI bus addresses. Software sets up a few windows through a 32-bit register port. Each of the two full windows holds a 64-bit local base, a 64-bit PCI base and a size/attribute word. A third window slot has only its size/attribute word. That word is stored and can be read back, but it never maps anything.

Lookups arrive on a valid/ready request stream. Each accepted address is compared, in the cycle it is accepted, with every enabled window, using the register state as it stands in that cycle. The verdict goes into a one-deep result stage: a hit flag, the winning window index and the translated PCI address.

Back-pressure rules:
- `req_ready` is high whenever the result stage is empty or its contents are being taken in the same cycle.
- A result whose `res_ready` is low stays valid and keeps its value until it is taken.

Top module: `ob_xlate_top`

## Requirements
- R1: After reset, every window register reads zero and every lookup reports a miss.
- R2: The register offsets are fixed:
  - Window 0: local base low 0x68, local base high 0x6C, size/attribute 0x70, PCI base low 0x74, PCI base high 0x78.
  - Window 1: the same five registers at 0x7C, 0x80, 0x84, 0x88 and 0x8C.
  - Window 2: size/attribute only, at 0x90.

  A write to one 32-bit half of a base replaces that half and leaves the other half unchanged. Reads return the stored value.
- R3: A window whose size/attribute bit 0 is zero never produces a hit.
- R4: Window span = two's complement of the size/attribute word with bit 0 cleared. When that span is zero it becomes 0xFFFFFFFF.
- R5: An address hits a window when base <= addr and addr - base < span. The result is then PCI base + (addr - base).
- R6: When two or more enabled windows hit, the lowest-numbered one is reported.
- R7: Writing window 2's size/attribute word only stores it. Window 2 never hits.
- R8: Offsets outside the map read as zero, and writes to them change no register.
- R9: Handshake and hold:
  - `req_ready` = !`res_valid` || `res_ready`.
  - An accepted request gives its result on the next cycle.
  - A result held with `res_ready` low keeps `res_hit`, `res_win` and `res_pci_addr` unchanged.
- R10: A miss reports `res_hit`=0, `res_win`=0 and `res_pci_addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted when high |
| req_addr | input | 64 | Local address to translate |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_hit | output | 1 | Address fell in an enabled window |
| res_win | output | 2 | Winning window index |
| res_pci_addr | output | 64 | Translated PCI address |

## Verification
The bench probes both ends of a window: the first byte, the last byte and the byte just past the end.
- A design with an off-by-one in the bound check would either miss the last byte or claim the first byte past the end.
- Two overlapping windows are probed in the shared region. Inverted priority would report window 1 and the wrong PCI address there.
- A size word of just the enable bit checks the clamp. Without it the window would be empty, or one byte too large.

A high-half base write followed by a readback of the low half catches a write that clobbers the whole 64-bit base. A result held against a low `res_ready` while a second request waits catches a stage that overwrites or drops data under back-pressure.

// File: rtl/oatw_pkg.sv
package oatw_pkg;
  localparam int DW        = 32;
  localparam int AW        = 2 * DW;
  localparam int NMAP      = 2;             // windows that translate
  localparam int WIN_IW    = 2;             // width of a window index
  localparam logic [7:0] OFF_BASE = 8'h68;  // first window register
  localparam int OFF_STRIDE = 20;           // bytes per full window

  typedef enum logic [2:0] {
    FLD_LB_LO = 3'd0,
    FLD_LB_HI = 3'd1,
    FLD_SA    = 3'd2,
    FLD_PB_LO = 3'd3,
    FLD_PB_HI = 3'd4
  } fld_e;

  // Byte offset of field f of window w
  function automatic logic [7:0] reg_off(int w, fld_e f);
    return 8'(int'(OFF_BASE) + w * OFF_STRIDE + int'(f) * 4);
  endfunction

  // Size-only register of the last window
  function automatic logic [7:0] tail_off();
    return reg_off(NMAP, FLD_LB_LO);
  endfunction

  // Span from the size/attribute word; a zero span is clamped
  function automatic logic [DW-1:0] win_span(logic [DW-1:0] sa);
    logic [DW-1:0] s;
    s = ~(sa & ~DW'(1)) + DW'(1);
    if (s == '0) s = '1;
    return s;
  endfunction

  typedef struct packed {
    logic              hit;
    logic [WIN_IW-1:0] win;
    logic [AW-1:0]     pci;
  } xres_t;
endpackage

// File: rtl/oatw_regs.sv
module oatw_regs
  import oatw_pkg::*;
#(
  parameter int NWIN = NMAP
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [7:0]               addr,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rdata,
  output logic [NWIN-1:0][AW-1:0]  lbase,
  output logic [NWIN-1:0][AW-1:0]  pbase,
  output logic [NWIN:0][DW-1:0]    sattr
);

  logic mapped;

  // Register writes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lbase <= '0;
      pbase <= '0;
      sattr <= '0;
    end else if (we) begin
      for (int i = 0; i < NWIN; i++) begin
        if (addr == reg_off(i, FLD_LB_LO)) lbase[i][DW-1:0]  <= wdata;
        if (addr == reg_off(i, FLD_LB_HI)) lbase[i][AW-1:DW] <= wdata;
        if (addr == reg_off(i, FLD_SA))    sattr[i]          <= wdata;
        if (addr == reg_off(i, FLD_PB_LO)) pbase[i][DW-1:0]  <= wdata;
        if (addr == reg_off(i, FLD_PB_HI)) pbase[i][AW-1:DW] <= wdata;
      end
      if (addr == tail_off()) sattr[NWIN] <= wdata;
    end
  end

  // Read mux; unmapped offsets read zero
  always_comb begin
    rdata  = '0;
    mapped = 1'b0;
    for (int i = 0; i < NWIN; i++) begin
      if (addr == reg_off(i, FLD_LB_LO)) begin rdata = lbase[i][DW-1:0];  mapped = 1'b1; end
      if (addr == reg_off(i, FLD_LB_HI)) begin rdata = lbase[i][AW-1:DW]; mapped = 1'b1; end
      if (addr == reg_off(i, FLD_SA))    begin rdata = sattr[i];          mapped = 1'b1; end
      if (addr == reg_off(i, FLD_PB_LO)) begin rdata = pbase[i][DW-1:0];  mapped = 1'b1; end
      if (addr == reg_off(i, FLD_PB_HI)) begin rdata = pbase[i][AW-1:DW]; mapped = 1'b1; end
    end
    if (addr == tail_off()) begin
      rdata  = sattr[NWIN];
      mapped = 1'b1;
    end
  end

  // R8
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !mapped) |=> ($stable(lbase) && $stable(pbase) && $stable(sattr)));

  for (genvar g = 0; g < NWIN; g++) begin : g_half
    // R2
    lo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == reg_off(g, FLD_LB_HI)) |=> $stable(lbase[g][DW-1:0]));
    // R2
    hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == reg_off(g, FLD_PB_LO)) |=> $stable(pbase[g][AW-1:DW]));
  end

endmodule

// File: rtl/oatw_match.sv
module oatw_match
  import oatw_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] lbase,
  input  logic [AW-1:0] pbase,
  input  logic [DW-1:0] attr,
  output logic          hit,
  output logic [AW-1:0] pci
);

  logic [AW-1:0] offset;
  logic [DW-1:0] span;

  always_comb begin
    offset = addr - lbase;
    span   = win_span(attr);
    hit    = attr[0] && (addr >= lbase) && (offset < AW'(span));
    pci    = pbase + offset;
  end

endmodule

// File: rtl/ob_xlate_top.sv
module ob_xlate_top
  import oatw_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [63:0]   req_addr,
  output logic          res_valid,
  input  logic          res_ready,
  output logic          res_hit,
  output logic [1:0]    res_win,
  output logic [63:0]   res_pci_addr
);

  logic [NMAP-1:0][AW-1:0] lbase;
  logic [NMAP-1:0][AW-1:0] pbase;
  logic [NMAP:0][DW-1:0]   sattr;
  logic [NMAP-1:0]         win_hit;
  logic [NMAP-1:0][AW-1:0] win_pci;
  xres_t                   pick;
  xres_t                   res_q;
  logic                    vld_q;

  oatw_regs #(.NWIN(NMAP)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .lbase (lbase),
    .pbase (pbase),
    .sattr (sattr)
  );

  for (genvar g = 0; g < NMAP; g++) begin : g_win
    oatw_match u_match (
      .addr  (req_addr),
      .lbase (lbase[g]),
      .pbase (pbase[g]),
      .attr  (sattr[g]),
      .hit   (win_hit[g]),
      .pci   (win_pci[g])
    );
    // R3
    win_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sattr[g][0] |-> !win_hit[g]);
  end

  // Lowest index wins
  always_comb begin
    pick = '0;
    for (int i = NMAP - 1; i >= 0; i--) begin
      if (win_hit[i]) begin
        pick.hit = 1'b1;
        pick.win = WIN_IW'(i);
        pick.pci = win_pci[i];
      end
    end
  end

  assign req_ready = !vld_q || res_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else if (req_ready) begin
      vld_q <= req_valid;
      if (req_valid) res_q <= pick;
    end
  end

  assign res_valid    = vld_q;
  assign res_hit      = res_q.hit;
  assign res_win      = res_q.win;
  assign res_pci_addr = res_q.pci;

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_hit) && $stable(res_win) && $stable(res_pci_addr)));
  // R7
  tail_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_hit && res_win == 2'd2));
  // R10
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_win == '0 && res_pci_addr == '0));

endmodule

// File: tb/tb_ob_xlate_top.sv
module tb_ob_xlate_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_hit;
  logic [1:0]  res_win;
  logic [63:0] res_pci_addr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ob_xlate_top dut (.*);

  localparam int NV = 7;
  localparam logic [63:0] V_ADDR [NV] = '{
    64'h1_8000_0000, 64'h1_8000_FFFF, 64'h1_8000_F900, 64'h1_8001_0000,
    64'h1_8001_0800, 64'h1_7FFF_FFFF, 64'h1_8001_07FF};
  localparam logic V_HIT [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic [1:0] V_WIN [NV] = '{2'd0, 2'd0, 2'd0, 2'd1, 2'd0, 2'd0, 2'd1};
  localparam logic [63:0] V_PCI [NV] = '{
    64'hAB_0000_0000, 64'hAB_0000_FFFF, 64'hAB_0000_F900, 64'h2000_0800,
    64'h0, 64'h0, 64'h2000_0FFF};

  task automatic check(string what, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_check(string what, logic [7:0] a, logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1 check(what, 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic look(string what, logic [63:0] a, logic h, logic [1:0] w, logic [63:0] p);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check({what, " valid"}, 64'(res_valid), 64'd1);
    check({what, " hit"}, 64'(res_hit), 64'(h));
    check({what, " win"}, 64'(res_win), 64'(w));
    check({what, " pci"}, res_pci_addr, p);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    rd_check("R1 lb0 lo", 8'h68, 32'h0);
    rd_check("R1 sa0", 8'h70, 32'h0);
    rd_check("R1 sa1", 8'h84, 32'h0);
    rd_check("R1 sa2", 8'h90, 32'h0);
    look("R1 miss after reset", 64'h0, 1'b0, 2'd0, 64'h0);

    // Program windows; R2 half writes
    wr(8'h68, 32'h8000_0000);
    wr(8'h6C, 32'h0000_0001);
    rd_check("R2 lb0 lo kept", 8'h68, 32'h8000_0000);
    rd_check("R2 lb0 hi", 8'h6C, 32'h0000_0001);
    wr(8'h74, 32'h0);
    wr(8'h78, 32'h0000_00AB);
    wr(8'h70, 32'hFFFF_0001);
    wr(8'h7C, 32'h8000_F800);
    wr(8'h80, 32'h0000_0001);
    wr(8'h88, 32'h2000_0000);
    wr(8'h8C, 32'h0);
    wr(8'h84, 32'hFFFF_F001);
    rd_check("R2 pb1 lo", 8'h88, 32'h2000_0000);
    rd_check("R2 sa1", 8'h84, 32'hFFFF_F001);
    wr(8'h78, 32'h0000_00AB);
    rd_check("R2 pb0 lo kept", 8'h74, 32'h0);

    // R5 R6 R10: vector table
    for (int i = 0; i < NV; i++)
      look($sformatf("R5/R6/R10 vec%0d", i), V_ADDR[i], V_HIT[i], V_WIN[i], V_PCI[i]);

    // R7: tail window stores but never maps
    wr(8'h90, 32'hFFFF_0001);
    rd_check("R7 sa2 stored", 8'h90, 32'hFFFF_0001);
    look("R7 tail never hits", 64'h0000_0000_0000_0010, 1'b0, 2'd0, 64'h0);

    // R8: unmapped offset
    wr(8'h94, 32'hDEAD_BEEF);
    rd_check("R8 unmapped reads zero", 8'h94, 32'h0);
    rd_check("R8 sa0 untouched", 8'h70, 32'hFFFF_0001);
    rd_check("R8 lb1 lo untouched", 8'h7C, 32'h8000_F800);

    // R3: disable window 0, overlap falls to window 1
    wr(8'h70, 32'hFFFF_0000);
    look("R3 w0 off overlap", 64'h1_8000_F900, 1'b1, 2'd1, 64'h2000_0100);
    look("R3 w0 off miss", 64'h1_8000_0000, 1'b0, 2'd0, 64'h0);

    // R4: clamp of a zero span
    wr(8'h70, 32'h0000_0001);
    look("R4 clamp last", 64'h2_7FFF_FFFE, 1'b1, 2'd0, 64'hAB_FFFF_FFFE);
    look("R4 clamp past", 64'h2_7FFF_FFFF, 1'b0, 2'd0, 64'h0);
    wr(8'h70, 32'hFFFF_F001);
    look("R4 4KiB end", 64'h1_8000_1000, 1'b0, 2'd0, 64'h0);
    look("R4 4KiB last", 64'h1_8000_0FFF, 1'b1, 2'd0, 64'hAB_0000_0FFF);

    // R9: back-pressure
    @(negedge clk);
    res_ready = 1'b0; req_valid = 1'b1; req_addr = 64'h1_8000_0004;
    @(negedge clk);
    req_addr = 64'h1_8001_0004;
    check("R9 valid", 64'(res_valid), 64'd1);
    check("R9 ready low", 64'(req_ready), 64'd0);
    @(negedge clk);
    @(negedge clk);
    check("R9 held pci", res_pci_addr, 64'hAB_0000_0004);
    check("R9 held win", 64'(res_win), 64'd0);
    res_ready = 1'b1;
    #1 check("R9 ready follows", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 next pci", res_pci_addr, 64'h2000_0804);
    check("R9 next win", 64'(res_win), 64'd1);
    @(negedge clk);
    check("R9 drained", 64'(res_valid), 64'd0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule